// File: doc/BRIEF.md
# Light Sensor Measurement Sequencer

This block sequences light measurements for an integrating light-to-digital sensor. A host writes an 8-bit command word that sets the power state, whether the block runs once or repeatedly, the sensing channel, the full-scale range and the timing scheme. The conversion itself happens in a separate converter stub. That stub receives a start pulse, the channel and the range, and it returns a running 16-bit count. At the end of each integration the sequencer captures that count, or in one external mode its own elapsed-cycle timer. It then raises an update strobe for one cycle.

Under internal timing the integration window is a fixed number of oscillator ticks: 16, 256, 4096 or 65536. Under external timing a host sync pulse opens the first window. Every later sync pulse closes the current window and opens the next one at once. In one-shot mode the block returns to power-down after its result and keeps the result on its output. A new command write always abandons any window in progress.

Top module: `lightseq_top`

## Requirements
- R1: After reset `active`, `timerOvf` and `updStrobe` are 0 and `dataOut` is 0.
- R2: Writing a command with bit 7 = 0 stops any integration, drops `active` in the next cycle, and produces no update. `dataOut` keeps its value.
- R3: Timing code bits 4:2 = 000/001/010/011 select internal timing of 65536/4096/256/16 ticks. Counting starts at the clock edge that captures the command. The update strobe is high in the cycle after the edge that counts the last tick. At that edge `dataOut` takes the `convCount` input.
- R4: With bit 6 = 0 (one-shot) the block clears `active` when its result arrives and holds `dataOut` afterwards.
- R5: With bit 6 = 1 (continuous) a new window starts as each one ends. With ticks on every cycle, internal-mode updates therefore come every 2^n cycles.
- R6: Under external timing (bit 4 = 1) the block is active but produces nothing until a sync pulse arrives. Each later sync ends the window, and the update strobe is high in the cycle after that sync is captured.
- R7: Timing code 100 reports the `convCount` value present at the edge that captures the ending sync.
- R8: Timing code 101 reports the number of tick-high cycles strictly between the cycle that captures the starting sync and the cycle that captures the ending sync.
- R9: The external timer stops at FFFFh. A further tick sets `timerOvf`, which stays set until the next sync pulse clears it.
- R10: Timing codes 110 and 111 power the block down, leaving `dataOut` unchanged and giving no update.
- R11: A command write during an integration discards that window and starts over under the new command from the write.
- R12: `convRange` follows command bits 1:0 and `convIr` follows bit 5. `convStart` is high for exactly one cycle after each edge that opens a window.
- R13: Only cycles with `oscTick` high advance the integration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write strobe |
| cmdData | input | 8 | Command word |
| syncPulse | input | 1 | External timing sync strobe |
| oscTick | input | 1 | Oscillator tick enable |
| convCount | input | 16 | Count from the converter stub |
| convStart | output | 1 | One-cycle pulse at each window start |
| convIr | output | 1 | Channel select to converter (1 = infrared) |
| convRange | output | 2 | Full-scale range to converter |
| dataOut | output | 16 | Latest measurement result |
| active | output | 1 | Powered/busy flag |
| updStrobe | output | 1 | One-cycle pulse when dataOut is refreshed |
| timerOvf | output | 1 | Sticky external timer overflow |

## Verification
An internal-mode result is due exactly 2^n cycles after the edge that captures its command, when ticks arrive every cycle. An external-mode result is due one cycle after the edge that captures the closing sync. `convStart` follows the window-opening edge by one cycle. Each time the driver issues a command or sync, it records the current cycle number and queues the expected value together with its due cycle. The monitor compares both the value and the cycle of every strobe it sees. A strobe that arrives with an empty queue, or an item left unconsumed at the end, counts as a miscompare, so aborted or suppressed windows are caught too.

// File: rtl/lightseq_pkg.sv
package lightseq_pkg;

  typedef enum logic [1:0] {
    S_OFF   = 2'd0,
    S_INTEG = 2'd1,
    S_ARM   = 2'd2,
    S_RUN   = 2'd3
  } seq_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
    logic satEn;
    logic latch;
    logic selTimer;
    logic clrOvf;
  } seq_ctl_t;

endpackage

// File: rtl/lightseq_ctrl.sv
module lightseq_ctrl
  import lightseq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [7:0]        cmdData,
  input  logic              syncPulse,
  input  logic              oscTick,
  input  logic              atTerm,
  output seq_ctl_t          ctl,
  output logic [DATA_W-1:0] termVal,
  output logic              active,
  output logic              convStart,
  output logic              convIr,
  output logic [1:0]        convRange
);

  seq_state_e state, nextState;
  logic       cfgCont;
  logic       cfgIr;
  logic [1:0] cfgRes;   // command bits 3:2
  logic [1:0] cfgRange;
  logic       startNow;

  logic newOff, newExt;
  assign newOff = !cmdData[7] || (cmdData[4] && cmdData[3]);
  assign newExt = cmdData[4];

  // each resolution step removes RES_STEP bits of the window length
  assign termVal = {DATA_W{1'b1}} >> (RES_STEP * cfgRes);

  always_comb begin
    nextState = state;
    ctl       = '0;
    startNow  = 1'b0;
    if (cmdWr) begin
      ctl.clrCnt = 1'b1;
      ctl.clrOvf = 1'b1;
      if (newOff)      nextState = S_OFF;
      else if (newExt) nextState = S_ARM;
      else begin
        nextState = S_INTEG;
        startNow  = 1'b1;
      end
    end else begin
      case (state)
        S_INTEG: begin
          ctl.cntEn = 1'b1;
          if (oscTick && atTerm) begin
            ctl.latch  = 1'b1;
            ctl.clrCnt = 1'b1;
            if (cfgCont) startNow = 1'b1;
            else         nextState = S_OFF;
          end
        end
        S_ARM: begin
          if (syncPulse) begin
            nextState  = S_RUN;
            ctl.clrCnt = 1'b1;
            ctl.clrOvf = 1'b1;
            startNow   = 1'b1;
          end
        end
        S_RUN: begin
          ctl.cntEn = 1'b1;
          ctl.satEn = 1'b1;
          if (syncPulse) begin
            ctl.latch    = 1'b1;
            ctl.selTimer = cfgRes[0];
            ctl.clrCnt   = 1'b1;
            ctl.clrOvf   = 1'b1;
            if (cfgCont) startNow = 1'b1;
            else         nextState = S_OFF;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_OFF;
      cfgCont   <= 1'b0;
      cfgIr     <= 1'b0;
      cfgRes    <= 2'd0;
      cfgRange  <= 2'd0;
      convStart <= 1'b0;
    end else begin
      state     <= nextState;
      convStart <= startNow;
      if (cmdWr) begin
        cfgCont  <= cmdData[6];
        cfgIr    <= cmdData[5];
        cfgRes   <= cmdData[3:2];
        cfgRange <= cmdData[1:0];
      end
    end
  end

  assign active    = (state != S_OFF);
  assign convIr    = cfgIr;
  assign convRange = cfgRange;

  // R4: a one-shot result returns the block to power-down
  p_oneshot_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latch && !cfgCont && !cmdWr) |=> (state == S_OFF));

  // R2: disabling command powers down in the next cycle
  p_power_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !cmdData[7]) |=> !active);

  // R12: window start pulse only while powered
  p_start_active_r12: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> active);

endmodule

// File: rtl/lightseq_dpath.sv
module lightseq_dpath
  import lightseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic              oscTick,
  input  logic [DATA_W-1:0] convCount,
  input  logic [DATA_W-1:0] termVal,
  output logic [DATA_W-1:0] dataOut,
  output logic              updStrobe,
  output logic              timerOvf,
  output logic              atTerm
);

  localparam logic [DATA_W-1:0] MAXV = {DATA_W{1'b1}};

  logic [DATA_W-1:0] cnt;

  assign atTerm = (cnt == termVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      dataOut   <= '0;
      updStrobe <= 1'b0;
      timerOvf  <= 1'b0;
    end else begin
      updStrobe <= ctl.latch;
      if (ctl.latch) dataOut <= ctl.selTimer ? cnt : convCount;

      if (ctl.clrCnt) begin
        cnt <= '0;
      end else if (ctl.cntEn && oscTick) begin
        if (cnt != MAXV) cnt <= cnt + 1'b1;
        else if (ctl.satEn) timerOvf <= 1'b1;
      end

      if (ctl.clrOvf) timerOvf <= 1'b0;
    end
  end

  // R9: overflow only once the timer has stuck at its ceiling
  p_ovf_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |-> (cnt == MAXV));

  // R10: result changes only together with an update
  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> updStrobe);

endmodule

// File: rtl/lightseq_top.sv
module lightseq_top
  import lightseq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [7:0]        cmdData,
  input  logic              syncPulse,
  input  logic              oscTick,
  input  logic [DATA_W-1:0] convCount,
  output logic              convStart,
  output logic              convIr,
  output logic [1:0]        convRange,
  output logic [DATA_W-1:0] dataOut,
  output logic              active,
  output logic              updStrobe,
  output logic              timerOvf
);

  seq_ctl_t          ctl;
  logic [DATA_W-1:0] termVal;
  logic              atTerm;

  lightseq_ctrl #(.DATA_W(DATA_W), .RES_STEP(RES_STEP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWr     (cmdWr),
    .cmdData   (cmdData),
    .syncPulse (syncPulse),
    .oscTick   (oscTick),
    .atTerm    (atTerm),
    .ctl       (ctl),
    .termVal   (termVal),
    .active    (active),
    .convStart (convStart),
    .convIr    (convIr),
    .convRange (convRange)
  );

  lightseq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .oscTick   (oscTick),
    .convCount (convCount),
    .termVal   (termVal),
    .dataOut   (dataOut),
    .updStrobe (updStrobe),
    .timerOvf  (timerOvf),
    .atTerm    (atTerm)
  );

  // R6: while armed and waiting for the first sync, no result appears
  p_arm_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (u_ctrl.state == S_ARM) |-> !updStrobe);

endmodule

// File: tb/sim_lightseq_top.sv
module sim_lightseq_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdWr;
  logic [7:0]  cmdData;
  logic        syncPulse;
  logic        oscTick;
  logic [15:0] convCount;
  logic        convStart, convIr;
  logic [1:0]  convRange;
  logic [15:0] dataOut;
  logic        active, updStrobe, timerOvf;

  always #4 clk = ~clk;  // 125 MHz

  lightseq_top u0 (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .syncPulse(syncPulse), .oscTick(oscTick), .convCount(convCount),
    .convStart(convStart), .convIr(convIr), .convRange(convRange),
    .dataOut(dataOut), .active(active), .updStrobe(updStrobe),
    .timerOvf(timerOvf)
  );

  int cycCnt = 0;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  typedef struct {
    logic [15:0] val;
    int          due;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  int nVec = 0;
  int nBad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input logic [15:0] v, input int due, input string tag);
    exp_t e;
    e.val = v; e.due = due; e.tag = tag;
    expQ.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rstN === 1'b1 && updStrobe === 1'b1) begin
      if (expQ.size() == 0) begin
        nVec++; nBad++;
        $display("FAIL R2/R10/R11 unexpected update actual=%0h expected=none at cycle %0d",
                 dataOut, cycCnt);
      end else begin
        e = expQ.pop_front();
        chk({e.tag, " data"}, dataOut, e.val);
        chk({e.tag, " cycle"}, cycCnt, e.due);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCmd(input logic [7:0] v);
    cmdData = v; cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic pulseSync();
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int c;
    int tickCnt;
    rstN = 1'b0; cmdWr = 1'b0; cmdData = 8'h00; syncPulse = 1'b0;
    oscTick = 1'b1; convCount = 16'h0000;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 active", active, 0);
    chk("R1 dataOut", dataOut, 0);
    chk("R1 timerOvf", timerOvf, 0);
    chk("R1 updStrobe", updStrobe, 0);

    // R12 + R3 + R4: one-shot, IR, 4-bit, range 2
    convCount = 16'h1234;
    c = cycCnt;
    pushExp(16'h1234, c + 1 + 16, "R3 n4");
    wrCmd(8'hAE);
    chk("R12 convStart", convStart, 1);
    chk("R12 convRange", convRange, 2);
    chk("R12 convIr", convIr, 1);
    chk("R4 active during", active, 1);
    idle(1);
    chk("R12 convStart single", convStart, 0);
    drain();
    chk("R4 active after", active, 0);
    idle(20);
    chk("R4 data held", dataOut, 16'h1234);

    // R3 other lengths: codes 2,1,0
    for (int r = 0; r < 3; r++) begin
      int code;
      code = 2 - r;
      convCount = 16'h0B00 + 16'(r);
      c = cycCnt;
      pushExp(convCount, c + 1 + (1 << (16 - 4 * code)), "R3 length");
      wrCmd(8'h80 | 8'(code << 2));
      drain();
      chk("R3 oneshot off", active, 0);
    end

    // R5 continuous, 4-bit
    convCount = 16'h00A5;
    c = cycCnt;
    pushExp(16'h00A5, c + 17, "R5 first");
    pushExp(16'h00A5, c + 33, "R5 second");
    pushExp(16'h00A5, c + 49, "R5 third");
    wrCmd(8'hCC);
    drain();
    chk("R5 still active", active, 1);
    idle(4);
    // R2 power down mid-window (other bits set)
    wrCmd(8'h4C);
    chk("R2 active", active, 0);
    idle(40);
    chk("R2 data kept", dataOut, 16'h00A5);

    // R11 abort and restart
    convCount = 16'h1111;
    wrCmd(8'h8C);
    idle(5);
    convCount = 16'h2222;
    c = cycCnt;
    pushExp(16'h2222, c + 17, "R11 restart");
    wrCmd(8'h8C);
    drain();
    idle(20);

    // R10 reserved codes
    wrCmd(8'hCC);
    idle(5);
    wrCmd(8'h98);
    chk("R10 code110 active", active, 0);
    idle(40);
    chk("R10 code110 data", dataOut, 16'h2222);
    wrCmd(8'hCC);
    idle(3);
    wrCmd(8'h9C);
    chk("R10 code111 active", active, 0);
    idle(30);
    chk("R10 code111 data", dataOut, 16'h2222);

    // R6 + R7 external conversion, continuous
    convCount = 16'h3333;
    wrCmd(8'hD0);
    chk("R6 armed active", active, 1);
    idle(30);
    pulseSync();
    idle(9);
    c = cycCnt;
    pushExp(16'h3333, c + 1, "R7 window1");
    pulseSync();
    idle(2);
    convCount = 16'h4444;
    idle(10);
    c = cycCnt;
    pushExp(16'h4444, c + 1, "R6 R7 window2");
    pulseSync();
    drain();
    chk("R6 continuous active", active, 1);
    wrCmd(8'h00);

    // R8 external timer, one-shot
    wrCmd(8'h94);
    pulseSync();
    idle(25);
    c = cycCnt;
    pushExp(16'd25, c + 1, "R8 timer");
    pulseSync();
    drain();
    chk("R8 oneshot off", active, 0);

    // R13 tick gating, continuous timer
    wrCmd(8'hD4);
    pulseSync();
    tickCnt = 0;
    for (int k = 0; k < 30; k++) begin
      oscTick = (k % 3 != 0);
      if (oscTick) tickCnt++;
      @(negedge clk);
    end
    oscTick = 1'b1;
    c = cycCnt;
    pushExp(16'(tickCnt), c + 1, "R13 gated");
    pulseSync();
    idle(12);
    c = cycCnt;
    pushExp(16'd12, c + 1, "R13 ungated");
    pulseSync();
    drain();
    wrCmd(8'h00);

    // R9 timer saturation and sticky overflow
    wrCmd(8'h94);
    pulseSync();
    chk("R9 ovf clear at start", timerOvf, 0);
    idle(65540);
    chk("R9 ovf set", timerOvf, 1);
    c = cycCnt;
    pushExp(16'hFFFF, c + 1, "R9 saturated");
    pulseSync();
    chk("R9 ovf cleared", timerOvf, 0);
    drain();
    chk("R9 oneshot off", active, 0);

    chk("final queue empty", expQ.size(), 0);
    finishRun();
  end

endmodule